// File: doc/BRIEF.md
# Translation Fault Status Sequencer

This block decides the outcome of one memory access in a 32-bit segmented address-translation unit. Each request carries an effective address, an access kind, an access class and a privilege level. It also carries two results worked out outside the block: the one from a block-translation matcher and the one from a page-table walker. The block also reads the control bits of sixteen segment registers. It tries the possible translation paths in a fixed order:

1. translation-off bypass
2. a block-translation hit
3. a direct-store segment
4. a no-execute segment
5. the page-table walk result together with its protection bits

The first path that applies gives the answer. The answer is either a translated address with read, write and execute rights, or a fault. A fault is one of three types (instruction-side, data-side, alignment) and carries an exact 32-bit status word.

One cycle after a request, the result appears with a single-cycle valid strobe. A fault-address register keeps the effective address of the most recent data-side or alignment fault. The execution pipeline uses the result to either issue the physical access or raise the matching exception.

Top module: `xlate_fault_seq`

## Requirements
- R1: With `req_real` set, the result carries no fault, status 0, address equal to the effective address, and read, write and execute all granted, whatever the other inputs are.
- R2: When translation is on and `blk_hit` is set, the block result is used before any segment information. If the block rights allow the access (fetch needs `blk_ex`, store needs `blk_wr`, load needs `blk_rd`), the address is `blk_addr` and the rights are copied from the block inputs.
- R3: A block hit whose rights deny the access faults as follows: a fetch gives an instruction fault (code 1) with status 0x08000000; a store gives a data fault (code 2) with status 0x0A000000; a load gives a data fault with 0x08000000.
- R4: The segment is chosen by effective-address bits 31:28. Segment i's control nibble is `seg_ctl[4i+3:4i]`, with bit 3 = direct-store, bit 2 = supervisor key, bit 1 = user key, bit 0 = no-execute. The protection key is the user key when `req_user` is 1 and the supervisor key otherwise.
- R5: In a direct-store segment, a fetch gives an instruction fault with 0x10000000. A float access (class 1) gives an alignment fault (code 3) with status 0. A reservation access (class 2) gives a data fault with 0x06000000 on store or 0x04000000 on load. An external-control access (class 4) gives a data fault with 0x06100000 on store or 0x04100000 on load. A cache operation (class 3) succeeds with address equal to the effective address and read-only rights.
- R6: A direct-store integer access (class 0) succeeds with the effective address as its address. Its rights are read, plus write when the key is 1. A store with key 0 is a data fault with 0x0A000000.
- R7: Outside bypass, block hit and direct-store, a fetch from a no-execute segment is an instruction fault with 0x10000000, whatever the walker reports.
- R8: If the walker reports no entry, a fetch gives an instruction fault with 0x40000000, a store gives a data fault with 0x42000000, and a load gives a data fault with 0x40000000.
- R9: For a found entry, rights come from the key and `walk_pp`. Key 0 gives read/write for PP 0–2 and read-only for PP 3. Key 1 gives no access for PP 0, read-only for PP 1 and PP 3, and read/write for PP 2. Execute equals read unless the segment is no-execute. A fetch or load needs read and a store needs write. A granted access has address `{walk_rpn, ea[11:0]}`. A denied access faults with the codes of R3.
- R10: `fault_addr` takes the effective address whenever a result is a data fault or an alignment fault. It keeps its value otherwise.
- R11: Every request yields exactly one `res_valid` pulse in the next cycle. Kind codes are 0 = fetch, 1 = load and 2 = store. Fault code 0 means none. A fault result grants no rights and has address 0. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| req_class | input | 3 | 0 integer, 1 float, 2 reservation, 3 cache op, 4 external |
| req_user | input | 1 | User privilege state |
| req_real | input | 1 | Translation disabled |
| blk_hit | input | 1 | Block matcher hit |
| blk_addr | input | 32 | Block-translated address |
| blk_rd | input | 1 | Block read right |
| blk_wr | input | 1 | Block write right |
| blk_ex | input | 1 | Block execute right |
| walk_found | input | 1 | Walker found an entry |
| walk_rpn | input | 20 | Real page number from the entry |
| walk_pp | input | 2 | Page protection field |
| seg_ctl | input | 64 | Control nibbles of the sixteen segment registers |
| res_valid | output | 1 | Result strobe |
| res_fault | output | 2 | 0 none, 1 instruction, 2 data, 3 alignment |
| res_status | output | 32 | Fault status word |
| res_addr | output | 32 | Translated address |
| res_rd | output | 1 | Read granted |
| res_wr | output | 1 | Write granted |
| res_ex | output | 1 | Execute granted |
| fault_addr | output | 32 | Address of the last data-side or alignment fault |

## Verification
Several decision paths can apply to one request at the same time. A block hit can fall on a direct-store or no-execute segment. A no-execute fetch can coincide with a walker miss. Bypass can coincide with all of these. The bench sweeps every combination of kind, class, privilege, bypass, block hit and rights, segment nibble, walker outcome and PP field. It places the segment under test at a rotating index while the other fifteen hold the complemented nibble. An independent priority model, written from the requirements, then judges which path won, and also judges the fault-address capture that happens alongside it in the same cycle.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_INSN  = 2'd1,
        FLT_DATA  = 2'd2,
        FLT_ALIGN = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_e;

    typedef enum logic [2:0] {
        CLS_INT   = 3'd0,
        CLS_FLOAT = 3'd1,
        CLS_RESV  = 3'd2,
        CLS_CACHE = 3'd3,
        CLS_EXT   = 3'd4
    } cls_e;

    localparam logic [31:0] ST_PROT_LD   = 32'h0800_0000;
    localparam logic [31:0] ST_PROT_ST   = 32'h0A00_0000;
    localparam logic [31:0] ST_NOEXEC    = 32'h1000_0000;
    localparam logic [31:0] ST_MISS_LD   = 32'h4000_0000;
    localparam logic [31:0] ST_MISS_ST   = 32'h4200_0000;
    localparam logic [31:0] ST_RESV_LD   = 32'h0400_0000;
    localparam logic [31:0] ST_RESV_ST   = 32'h0600_0000;
    localparam logic [31:0] ST_EXTC_LD   = 32'h0410_0000;
    localparam logic [31:0] ST_EXTC_ST   = 32'h0610_0000;

    // Decision outcome without the address
    typedef struct packed {
        fault_e      fault;
        logic [31:0] status;
        logic        rd;
        logic        wr;
        logic        ex;
    } verdict_t;

    function automatic verdict_t grant(input logic rd, input logic wr, input logic ex);
        verdict_t v;
        v.fault  = FLT_NONE;
        v.status = '0;
        v.rd     = rd;
        v.wr     = wr;
        v.ex     = ex;
        return v;
    endfunction

    function automatic verdict_t deny(input fault_e f, input logic [31:0] st);
        verdict_t v;
        v.fault  = f;
        v.status = st;
        v.rd     = 1'b0;
        v.wr     = 1'b0;
        v.ex     = 1'b0;
        return v;
    endfunction

    // Protection refusal, shared by block and page paths
    function automatic verdict_t prot_refusal(input logic is_fetch, input logic is_store);
        if (is_fetch)      return deny(FLT_INSN, ST_PROT_LD);
        else if (is_store) return deny(FLT_DATA, ST_PROT_ST);
        else               return deny(FLT_DATA, ST_PROT_LD);
    endfunction

endpackage

// File: rtl/xl_seg_pick.sv
module xl_seg_pick #(
    parameter int ADDR_W  = 32,
    parameter int NUM_SEG = 16,
    localparam int IDX_W  = $clog2(NUM_SEG)
) (
    input  logic [NUM_SEG*4-1:0] seg_ctl,
    input  logic [IDX_W-1:0]     seg_idx,
    input  logic                 user,
    output logic                 direct,
    output logic                 no_exec,
    output logic                 key
);
    logic [3:0] nib [NUM_SEG];

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SEG; gi++) begin : g_unpack
            assign nib[gi] = seg_ctl[gi*4 +: 4];
        end
    endgenerate

    logic [3:0] sel;
    assign sel     = nib[seg_idx];
    assign direct  = sel[3];
    assign no_exec = sel[0];
    assign key     = user ? sel[1] : sel[2];
endmodule

// File: rtl/xl_pp_rights.sv
module xl_pp_rights (
    input  logic       key,
    input  logic [1:0] pp,
    output logic       rd,
    output logic       wr
);
    always_comb begin
        if (!key) begin
            rd = 1'b1;
            wr = (pp != 2'b11);
        end else begin
            rd = (pp != 2'b00);
            wr = (pp == 2'b10);
        end
    end
endmodule

// File: rtl/xl_dstore.sv
module xl_dstore
    import xlate_pkg::*;
(
    input  logic     is_fetch,
    input  logic     is_store,
    input  logic [2:0] cls,
    input  logic     key,
    output verdict_t verdict
);
    always_comb begin
        if (is_fetch) begin
            verdict = deny(FLT_INSN, ST_NOEXEC);
        end else begin
            case (cls)
                CLS_FLOAT: verdict = deny(FLT_ALIGN, 32'h0);
                CLS_RESV:  verdict = deny(FLT_DATA, is_store ? ST_RESV_ST : ST_RESV_LD);
                CLS_EXT:   verdict = deny(FLT_DATA, is_store ? ST_EXTC_ST : ST_EXTC_LD);
                CLS_CACHE: verdict = grant(1'b1, 1'b0, 1'b0);
                default: begin
                    if (is_store && !key) verdict = deny(FLT_DATA, ST_PROT_ST);
                    else                  verdict = grant(1'b1, key, 1'b0);
                end
            endcase
        end
    end
endmodule

// File: rtl/xlate_fault_seq.sv
module xlate_fault_seq
    import xlate_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NUM_SEG   = 16,
    parameter int PAGE_BITS = 12,
    localparam int IDX_W    = $clog2(NUM_SEG),
    localparam int RPN_W    = ADDR_W - PAGE_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_ea,
    input  logic [1:0]           req_kind,
    input  logic [2:0]           req_class,
    input  logic                 req_user,
    input  logic                 req_real,
    input  logic                 blk_hit,
    input  logic [ADDR_W-1:0]    blk_addr,
    input  logic                 blk_rd,
    input  logic                 blk_wr,
    input  logic                 blk_ex,
    input  logic                 walk_found,
    input  logic [RPN_W-1:0]     walk_rpn,
    input  logic [1:0]           walk_pp,
    input  logic [NUM_SEG*4-1:0] seg_ctl,
    output logic                 res_valid,
    output logic [1:0]           res_fault,
    output logic [31:0]          res_status,
    output logic [ADDR_W-1:0]    res_addr,
    output logic                 res_rd,
    output logic                 res_wr,
    output logic                 res_ex,
    output logic [ADDR_W-1:0]    fault_addr
);
    typedef struct packed {
        logic              valid;
        verdict_t          verdict;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] far;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic is_fetch, is_store;
    assign is_fetch = (req_kind == ACC_FETCH);
    assign is_store = (req_kind == ACC_STORE);

    logic seg_direct, seg_nx, seg_key;
    xl_seg_pick #(.ADDR_W(ADDR_W), .NUM_SEG(NUM_SEG)) u_seg (
        .seg_ctl (seg_ctl),
        .seg_idx (req_ea[ADDR_W-1 -: IDX_W]),
        .user    (req_user),
        .direct  (seg_direct),
        .no_exec (seg_nx),
        .key     (seg_key)
    );

    logic pg_rd, pg_wr;
    xl_pp_rights u_pp (
        .key (seg_key),
        .pp  (walk_pp),
        .rd  (pg_rd),
        .wr  (pg_wr)
    );

    verdict_t ds_verdict;
    xl_dstore u_ds (
        .is_fetch (is_fetch),
        .is_store (is_store),
        .cls      (req_class),
        .key      (seg_key),
        .verdict  (ds_verdict)
    );

    verdict_t          vd_c;
    logic [ADDR_W-1:0] addr_c;
    logic              need_ok;

    always_comb begin
        st_d       = st_q;
        st_d.valid = req_valid;
        vd_c       = grant(1'b1, 1'b1, 1'b1);
        addr_c     = req_ea;
        need_ok    = 1'b0;

        if (req_real) begin
            vd_c   = grant(1'b1, 1'b1, 1'b1);
            addr_c = req_ea;
        end else if (blk_hit) begin
            need_ok = is_fetch ? blk_ex : (is_store ? blk_wr : blk_rd);
            if (need_ok) begin
                vd_c   = grant(blk_rd, blk_wr, blk_ex);
                addr_c = blk_addr;
            end else begin
                vd_c = prot_refusal(is_fetch, is_store);
            end
        end else if (seg_direct) begin
            vd_c   = ds_verdict;
            addr_c = req_ea;
        end else if (is_fetch && seg_nx) begin
            vd_c = deny(FLT_INSN, ST_NOEXEC);
        end else if (!walk_found) begin
            if (is_fetch)      vd_c = deny(FLT_INSN, ST_MISS_LD);
            else if (is_store) vd_c = deny(FLT_DATA, ST_MISS_ST);
            else               vd_c = deny(FLT_DATA, ST_MISS_LD);
        end else begin
            need_ok = is_store ? pg_wr : pg_rd;
            if (need_ok) begin
                vd_c   = grant(pg_rd, pg_wr, pg_rd & ~seg_nx);
                addr_c = {walk_rpn, req_ea[PAGE_BITS-1:0]};
            end else begin
                vd_c = prot_refusal(is_fetch, is_store);
            end
        end

        if (vd_c.fault != FLT_NONE) addr_c = '0;

        if (req_valid) begin
            st_d.verdict = vd_c;
            st_d.addr    = addr_c;
            if (vd_c.fault == FLT_DATA || vd_c.fault == FLT_ALIGN) st_d.far = req_ea;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid  = st_q.valid;
    assign res_fault  = st_q.verdict.fault;
    assign res_status = st_q.verdict.status;
    assign res_addr   = st_q.addr;
    assign res_rd     = st_q.verdict.rd;
    assign res_wr     = st_q.verdict.wr;
    assign res_ex     = st_q.verdict.ex;
    assign fault_addr = st_q.far;

    // R11: one strobe per request, in the following cycle
    a_r11_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (res_valid == $past(req_valid)));

    // R11: a fault grants nothing and carries no address
    a_r11_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault != 2'd0) |-> (!res_rd && !res_wr && !res_ex && res_addr == '0));

    // R1: bypass passes the address with full rights
    a_r1_real_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_real) |=> (res_fault == 2'd0 && res_addr == $past(req_ea)
                                     && res_rd && res_wr && res_ex));

    // R7: no-execute fetch faults before the walker result matters
    a_r7_nx_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_real && !blk_hit && !seg_direct && seg_nx && is_fetch)
        |=> (res_fault == 2'd1 && res_status == 32'h1000_0000));

    // R10: data-side faults capture the effective address
    a_r10_far_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && res_valid && (res_fault == 2'd2 || res_fault == 2'd3) && $past(rst_n))
        |-> (fault_addr == $past(req_ea)));

    // R10: no data-side fault, no change
    a_r10_far_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(res_valid && (res_fault == 2'd2 || res_fault == 2'd3)) && $past(rst_n))
        |-> (fault_addr == $past(fault_addr)));
endmodule

// File: tb/xlate_fault_seq_test.sv
module xlate_fault_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_ea = '0;
    logic [1:0]  req_kind = '0;
    logic [2:0]  req_class = '0;
    logic        req_user = 1'b0, req_real = 1'b0;
    logic        blk_hit = 1'b0, blk_rd = 1'b0, blk_wr = 1'b0, blk_ex = 1'b0;
    logic [31:0] blk_addr = '0;
    logic        walk_found = 1'b0;
    logic [19:0] walk_rpn = '0;
    logic [1:0]  walk_pp = '0;
    logic [63:0] seg_ctl = '0;
    logic        res_valid, res_rd, res_wr, res_ex;
    logic [1:0]  res_fault;
    logic [31:0] res_status, res_addr, fault_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlate_fault_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
        .req_kind(req_kind), .req_class(req_class), .req_user(req_user),
        .req_real(req_real), .blk_hit(blk_hit), .blk_addr(blk_addr),
        .blk_rd(blk_rd), .blk_wr(blk_wr), .blk_ex(blk_ex),
        .walk_found(walk_found), .walk_rpn(walk_rpn), .walk_pp(walk_pp),
        .seg_ctl(seg_ctl), .res_valid(res_valid), .res_fault(res_fault),
        .res_status(res_status), .res_addr(res_addr), .res_rd(res_rd),
        .res_wr(res_wr), .res_ex(res_ex), .fault_addr(fault_addr)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [1:0]  e_fault;
    logic [31:0] e_status, e_addr, e_far;
    logic        e_rd, e_wr, e_ex;
    string       e_tag;

    task automatic set_ok(input logic [31:0] a, input logic r, input logic w, input logic x, input string tag);
        e_fault = 2'd0; e_status = 32'h0; e_addr = a; e_rd = r; e_wr = w; e_ex = x; e_tag = tag;
    endtask

    task automatic set_flt(input logic [1:0] f, input logic [31:0] s, input string tag);
        e_fault = f; e_status = s; e_addr = 32'h0; e_rd = 0; e_wr = 0; e_ex = 0; e_tag = tag;
    endtask

    // Independent priority model of the requirements
    task automatic model(input int kind, input int cls, input bit usr, input bit rl,
                         input bit bh, input bit [2:0] br, input bit [3:0] s,
                         input bit wf, input bit [1:0] pp);
        bit fetch, store, t, n, key, prd, pwr, need;
        fetch = (kind == 0);
        store = (kind == 2);
        t = s[3]; n = s[0];
        key = usr ? s[1] : s[2];                          // R4
        if (rl) begin
            set_ok(req_ea, 1, 1, 1, "R1");
        end else if (bh) begin
            need = fetch ? br[0] : (store ? br[1] : br[2]);
            if (need) set_ok(blk_addr, br[2], br[1], br[0], "R2");
            else if (fetch) set_flt(1, 32'h0800_0000, "R3");
            else if (store) set_flt(2, 32'h0A00_0000, "R3");
            else            set_flt(2, 32'h0800_0000, "R3");
        end else if (t) begin
            if (fetch) set_flt(1, 32'h1000_0000, "R5");
            else case (cls)
                1: set_flt(3, 32'h0, "R5");
                2: set_flt(2, store ? 32'h0600_0000 : 32'h0400_0000, "R5");
                3: set_ok(req_ea, 1, 0, 0, "R5");
                4: set_flt(2, store ? 32'h0610_0000 : 32'h0410_0000, "R5");
                default: begin
                    if (store && !key) set_flt(2, 32'h0A00_0000, "R6");
                    else               set_ok(req_ea, 1, key, 0, "R6");
                end
            endcase
        end else if (fetch && n) begin
            set_flt(1, 32'h1000_0000, "R7");
        end else if (!wf) begin
            if (fetch)      set_flt(1, 32'h4000_0000, "R8");
            else if (store) set_flt(2, 32'h4200_0000, "R8");
            else            set_flt(2, 32'h4000_0000, "R8");
        end else begin
            if (!key) begin prd = 1; pwr = (pp != 3); end
            else begin prd = (pp != 0); pwr = (pp == 2); end
            need = store ? pwr : prd;
            if (need) set_ok({walk_rpn, req_ea[11:0]}, prd, pwr, prd & ~n, "R9");
            else if (fetch) set_flt(1, 32'h0800_0000, "R9");
            else if (store) set_flt(2, 32'h0A00_0000, "R9");
            else            set_flt(2, 32'h0800_0000, "R9");
        end
        if (e_fault == 2 || e_fault == 3) e_far = req_ea;  // R10
    endtask

    task automatic check_result();
        checks++;
        if (res_valid !== 1'b1 || res_fault !== e_fault || res_status !== e_status ||
            res_addr !== e_addr || res_rd !== e_rd || res_wr !== e_wr || res_ex !== e_ex ||
            fault_addr !== e_far) begin
            fails++;
            $display("FAIL %s/R10/R11: got v=%0b f=%0d st=%h a=%h r%0b w%0b x%0b far=%h exp f=%0d st=%h a=%h r%0b w%0b x%0b far=%h",
                     e_tag, res_valid, res_fault, res_status, res_addr, res_rd, res_wr, res_ex,
                     fault_addr, e_fault, e_status, e_addr, e_rd, e_wr, e_ex, e_far);
        end
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired: got running, expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        int vec;
        vec = 0;
        e_far = 32'h0;
        repeat (3) @(negedge clk);
        // R11: reset state
        checks++;
        if (res_valid !== 0 || res_fault !== 0 || res_status !== 0 || res_addr !== 0 ||
            res_rd !== 0 || res_wr !== 0 || res_ex !== 0 || fault_addr !== 0) begin
            fails++;
            $display("FAIL R11 reset: got v=%0b f=%0d st=%h far=%h expected all 0",
                     res_valid, res_fault, res_status, fault_addr);
        end
        rst_n = 1'b1;
        @(negedge clk);
        for (int kind = 0; kind < 3; kind++)
        for (int cls = 0; cls < 5; cls++)
        for (int usr = 0; usr < 2; usr++)
        for (int rl = 0; rl < 2; rl++)
        for (int bh = 0; bh < 2; bh++)
        for (int br = 0; br < 8; br++)
        for (int s = 0; s < 16; s++)
        for (int wf = 0; wf < 2; wf++)
        for (int pp = 0; pp < 4; pp++) begin
            logic [3:0]  idx;
            logic [31:0] mix;
            if (vec > 0) check_result();
            idx = 4'(vec * 7 + s);
            mix = 32'(vec) * 32'h9E37_79B1;
            req_valid  = 1'b1;
            req_ea     = {idx, mix[27:0]};
            req_kind   = 2'(kind);
            req_class  = 3'(cls);
            req_user   = usr[0];
            req_real   = rl[0];
            blk_hit    = bh[0];
            blk_rd     = br[2]; blk_wr = br[1]; blk_ex = br[0];
            blk_addr   = req_ea ^ 32'hABCD_E000;
            walk_found = wf[0];
            walk_pp    = 2'(pp);
            walk_rpn   = mix[31:12] ^ 20'h13579;
            for (int k = 0; k < 16; k++)
                seg_ctl[k*4 +: 4] = (4'(k) == idx) ? 4'(s) : ~4'(s);
            model(kind, cls, usr[0], rl[0], bh[0], 3'(br), 4'(s), wf[0], 2'(pp));
            vec++;
            @(negedge clk);
        end
        check_result();
        req_valid = 1'b0;
        req_ea    = 32'hFFFF_FFFF;
        @(negedge clk);
        // R11 and R10: idle cycle gives no strobe and keeps the fault address
        checks++;
        if (res_valid !== 1'b0 || fault_addr !== e_far) begin
            fails++;
            $display("FAIL R11/R10 idle: got v=%0b far=%h expected v=0 far=%h",
                     res_valid, fault_addr, e_far);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule